// File: doc/BRIEF.md
# Nibble-Wise Parity Matrix Codec

This block guards a 32-bit data word against scattered bit upsets in storage. The encode path cuts the word into eight independent 4-bit groups and gives each group three parity bits, so each group becomes a 7-bit codeword. The eight codewords are packed into one 56-bit stored word, which is 24 redundant bits per data word.

The decode path takes a 56-bit word read back from storage and recomputes the three parity bits of every group from that group's data bits. It compares them with the stored parity bits to form a 3-bit syndrome per group. A syndrome that points at a data bit inverts that bit. A syndrome that points at a parity bit leaves the data untouched. Because the groups are separate, one upset in each of the eight groups (up to eight upsets in all) is repaired in a single pass. Both paths have one register stage, with a valid strobe that travels alongside the data.

Top module: `pmc_codec`

## Requirements
- R1: In the cycle after a clock edge with `rst` high, every output is zero.
- R2: Data bits [4k+3:4k] form group k, with d1 = bit 4k through d4 = bit 4k+3. Group k's codeword sits in stored bits [7k+6:7k], ordered p1 (bit 7k), p2, p3, d1, d2, d3, d4 (bit 7k+6).
- R3: The parity bits are p1 = d2^d3^d4, p2 = d1^d3^d4 and p3 = d1^d2^d4.
- R4: `enc_out_valid` equals `enc_in_valid` from one cycle earlier, and `dec_out_valid` equals `dec_in_valid` from one cycle earlier. The result of a word accepted on one edge appears after that same edge.
- R5: A stored word with no upset decodes to the original data, with a zero error vector and a low summary flag.
- R6: A single flipped data bit in a group is corrected. The syndrome bits (p1, p2, p3 mismatch) select the bit to invert: p2 and p3 invert d1, p1 and p3 invert d2, p1 and p2 invert d3, and all three invert d4.
- R7: A single flipped parity bit in a group leaves that group's data unchanged and still marks the group as in error.
- R8: One upset in each of several groups, up to all eight, is corrected in the same decode.
- R9: Bit k of `dec_out_err_vec` is set exactly when group k has a nonzero syndrome. `dec_out_err_any` is the OR of all eight bits.
- R10: While an input valid strobe is low, that path's data outputs keep their previous values, whatever its data input does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enc_in_valid | input | 1 | Encode request strobe |
| enc_in_data | input | 32 | Data word to encode |
| enc_out_valid | output | 1 | Encoded word is valid |
| enc_out_word | output | 56 | Packed 56-bit stored word |
| dec_in_valid | input | 1 | Decode request strobe |
| dec_in_word | input | 56 | Stored word read back |
| dec_out_valid | output | 1 | Decoded data is valid |
| dec_out_data | output | 32 | Corrected data word |
| dec_out_err_vec | output | 8 | Per-group nonzero-syndrome flags |
| dec_out_err_any | output | 1 | OR of the per-group flags |

## Verification
The assertions on the correction path assume that each group of the read word holds at most one flipped bit. They also assume the word is free of unknown values. Under those conditions, a repair changes at most one data bit per group, and a zero syndrome passes the data through unchanged. The stimulus keeps within this: every vector builds its upset mask from at most one bit position per group. The hold checks toggle the data inputs only while the valid strobes are low.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  localparam int GRP_DW = 4;
  localparam int GRP_PW = 3;
  localparam int GRP_CW = GRP_DW + GRP_PW;

  // Check bits of one nibble: index 0 = p1, 1 = p2, 2 = p3.
  function automatic logic [GRP_PW-1:0] nib_parity(input logic [GRP_DW-1:0] d);
    logic [GRP_PW-1:0] p;
    p[0] = d[1] ^ d[2] ^ d[3];
    p[1] = d[0] ^ d[2] ^ d[3];
    p[2] = d[0] ^ d[1] ^ d[3];
    return p;
  endfunction
endpackage

// File: rtl/pmc_grp_enc.sv
module pmc_grp_enc
  import pmc_pkg::*;
(
  input  logic [GRP_DW-1:0] nib_i,
  output logic [GRP_CW-1:0] cw_o
);
  always_comb begin
    cw_o = {nib_i, nib_parity(nib_i)};
  end
endmodule

// File: rtl/pmc_grp_dec.sv
module pmc_grp_dec
  import pmc_pkg::*;
(
  input  logic [GRP_CW-1:0] cw_i,
  output logic [GRP_DW-1:0] nib_o,
  output logic              err_o
);
  logic [GRP_DW-1:0] rd_nib;
  logic [GRP_PW-1:0] syn;
  logic [GRP_DW-1:0] flip;

  always_comb begin
    rd_nib = cw_i[GRP_CW-1:GRP_PW];
    syn    = cw_i[GRP_PW-1:0] ^ nib_parity(rd_nib);
    unique case (syn)
      3'b110:  flip = 4'b0001;
      3'b101:  flip = 4'b0010;
      3'b011:  flip = 4'b0100;
      3'b111:  flip = 4'b1000;
      default: flip = 4'b0000;
    endcase
    nib_o = rd_nib ^ flip;
    err_o = |syn;
  end

  always_comb begin
    if (!$isunknown(cw_i)) begin
      a_r6_one_bit_repair: assert ($countones(nib_o ^ cw_i[GRP_CW-1:GRP_PW]) <= 1)
        else $error("R6: repair changed more than one data bit");
      a_r5_clean_passthru: assert (err_o || (nib_o == cw_i[GRP_CW-1:GRP_PW]))
        else $error("R5: clean group altered");
    end
  end
endmodule

// File: rtl/pmc_codec.sv
module pmc_codec
  import pmc_pkg::*;
#(
  parameter int NGRP = 8,
  localparam int DATA_W = NGRP * GRP_DW,
  localparam int STORE_W = NGRP * GRP_CW
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               enc_in_valid,
  input  logic [DATA_W-1:0]  enc_in_data,
  output logic               enc_out_valid,
  output logic [STORE_W-1:0] enc_out_word,
  input  logic               dec_in_valid,
  input  logic [STORE_W-1:0] dec_in_word,
  output logic               dec_out_valid,
  output logic [DATA_W-1:0]  dec_out_data,
  output logic [NGRP-1:0]    dec_out_err_vec,
  output logic               dec_out_err_any
);
  logic [STORE_W-1:0] enc_word_c;
  logic [DATA_W-1:0]  dec_data_c;
  logic [NGRP-1:0]    dec_err_c;

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    pmc_grp_enc u_enc (
      .nib_i (enc_in_data[g*GRP_DW +: GRP_DW]),
      .cw_o  (enc_word_c[g*GRP_CW +: GRP_CW])
    );
    pmc_grp_dec u_dec (
      .cw_i  (dec_in_word[g*GRP_CW +: GRP_CW]),
      .nib_o (dec_data_c[g*GRP_DW +: GRP_DW]),
      .err_o (dec_err_c[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      enc_out_valid <= 1'b0;
      enc_out_word  <= '0;
    end else begin
      enc_out_valid <= enc_in_valid;
      if (enc_in_valid) enc_out_word <= enc_word_c;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dec_out_valid   <= 1'b0;
      dec_out_data    <= '0;
      dec_out_err_vec <= '0;
      dec_out_err_any <= 1'b0;
    end else begin
      dec_out_valid <= dec_in_valid;
      if (dec_in_valid) begin
        dec_out_data    <= dec_data_c;
        dec_out_err_vec <= dec_err_c;
        dec_out_err_any <= |dec_err_c;
      end
    end
  end

  a_r4_enc_latency: assert property (@(posedge clk) disable iff (rst)
    enc_in_valid |=> enc_out_valid)
    else $error("R4: encode valid lost");
  a_r4_dec_latency: assert property (@(posedge clk) disable iff (rst)
    !dec_in_valid |=> !dec_out_valid)
    else $error("R4: spurious decode valid");
  a_r10_enc_hold: assert property (@(posedge clk) disable iff (rst)
    !enc_in_valid |=> $stable(enc_out_word))
    else $error("R10: encode output moved while idle");
  a_r10_dec_hold: assert property (@(posedge clk) disable iff (rst)
    !dec_in_valid |=> ($stable(dec_out_data) && $stable(dec_out_err_vec)))
    else $error("R10: decode output moved while idle");
  a_r9_flag_summary: assert property (@(posedge clk) disable iff (rst)
    dec_out_valid |-> (dec_out_err_any == (dec_out_err_vec != '0)))
    else $error("R9: summary flag disagrees with vector");
endmodule

// File: tb/pmc_codec_tb_top.sv
module pmc_codec_tb_top;
  localparam int NG = 8;
  localparam int DW = NG * 4;
  localparam int SW = NG * 7;
  localparam int NV = 8;

  // Each entry: {data, per-group upset position code}. Hex digit k of the
  // code is the bit position (0..6) hit in group k; 15 means no upset.
  localparam logic [63:0] VEC [NV] = '{
    {32'h00000000, 32'hFFFFFFFF},
    {32'hFFFFFFFF, 32'hFFFFFFF0},
    {32'h12345678, 32'h6543210F},
    {32'hDEADBEEF, 32'h01234566},
    {32'hA5A5A5A5, 32'h3333FFFF},
    {32'h5A5A5A5A, 32'hF4F5F6F3},
    {32'h80000001, 32'h6FFFFFF3},
    {32'hCAFEF00D, 32'hFFFFFFFF}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic enc_in_valid = 1'b0;
  logic [DW-1:0] enc_in_data = '0;
  logic enc_out_valid;
  logic [SW-1:0] enc_out_word;
  logic dec_in_valid = 1'b0;
  logic [SW-1:0] dec_in_word = '0;
  logic dec_out_valid;
  logic [DW-1:0] dec_out_data;
  logic [NG-1:0] dec_out_err_vec;
  logic dec_out_err_any;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pmc_codec #(.NGRP(NG)) dut_i (
    .clk, .rst, .enc_in_valid, .enc_in_data, .enc_out_valid, .enc_out_word,
    .dec_in_valid, .dec_in_word, .dec_out_valid, .dec_out_data,
    .dec_out_err_vec, .dec_out_err_any
  );

  function automatic logic [SW-1:0] ref_encode(input logic [DW-1:0] d);
    logic [SW-1:0] w;
    for (int g = 0; g < NG; g++) begin
      logic [3:0] n;
      n = d[4*g +: 4];
      w[7*g + 0] = n[1] ^ n[2] ^ n[3];
      w[7*g + 1] = n[0] ^ n[2] ^ n[3];
      w[7*g + 2] = n[0] ^ n[1] ^ n[3];
      w[7*g + 3 +: 4] = n;
    end
    return w;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] d;
    logic [31:0] pc;
    logic [SW-1:0] mask;
    logic [NG-1:0] xerr;
    logic [SW-1:0] hold_w;

    repeat (3) @(negedge clk);
    chk("R1 enc_out_word", 64'(enc_out_word), 64'(0));
    chk("R1 valids", {62'd0, enc_out_valid, dec_out_valid}, 64'd0);
    chk("R1 dec_out_data", 64'(dec_out_data), 64'(0));
    chk("R1 err", {55'd0, dec_out_err_vec, dec_out_err_any}, 64'd0);
    rst = 1'b0;

    for (int v = 0; v < NV; v++) begin
      d  = VEC[v][63:32];
      pc = VEC[v][31:0];
      mask = '0;
      xerr = '0;
      for (int g = 0; g < NG; g++) begin
        if (pc[4*g +: 4] < 4'd7) begin
          mask[7*g + int'(pc[4*g +: 4])] = 1'b1;
          xerr[g] = 1'b1;
        end
      end
      @(negedge clk);
      enc_in_valid = 1'b1;
      enc_in_data  = d;
      @(negedge clk);
      enc_in_valid = 1'b0;
      chk("R4 enc_out_valid", 64'(enc_out_valid), 64'd1);
      chk("R2 R3 enc_out_word", 64'(enc_out_word), 64'(ref_encode(d)));
      dec_in_valid = 1'b1;
      dec_in_word  = enc_out_word ^ mask;
      @(negedge clk);
      dec_in_valid = 1'b0;
      chk("R4 dec_out_valid", 64'(dec_out_valid), 64'd1);
      chk("R5 R6 R7 R8 dec_out_data", 64'(dec_out_data), 64'(d));
      chk("R9 dec_out_err_vec", 64'(dec_out_err_vec), 64'(xerr));
      chk("R9 dec_out_err_any", 64'(dec_out_err_any), 64'(xerr != '0));
    end

    // R6: every data position of group 5 individually, on a fresh pattern
    for (int b = 3; b < 7; b++) begin
      @(negedge clk);
      dec_in_valid = 1'b1;
      dec_in_word  = ref_encode(32'h0F1E2D3C) ^ (SW'(1) << (7*5 + b));
      @(negedge clk);
      dec_in_valid = 1'b0;
      chk("R6 single data bit", {dec_out_err_vec, dec_out_data}, {8'h20, 32'h0F1E2D3C});
    end

    // R7: parity-only upsets in every group, data untouched
    @(negedge clk);
    dec_in_valid = 1'b1;
    dec_in_word  = ref_encode(32'h3C3C3C3C) ^ {NG{7'b0000010}};
    @(negedge clk);
    dec_in_valid = 1'b0;
    chk("R7 parity upsets", {dec_out_err_vec, dec_out_data}, {8'hFF, 32'h3C3C3C3C});

    // R10: inputs change with valid low; outputs must hold
    hold_w = enc_out_word;
    enc_in_data = 32'h13572468;
    dec_in_word = {SW{1'b1}};
    @(negedge clk);
    @(negedge clk);
    chk("R10 enc hold", 64'(enc_out_word), 64'(hold_w));
    chk("R10 dec hold", {dec_out_err_vec, dec_out_data}, {8'hFF, 32'h3C3C3C3C});
    chk("R4 valids low", {62'd0, enc_out_valid, dec_out_valid}, 64'd0);

    // R1: reset mid-run clears everything
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R1 reset clears", {7'd0, dec_out_err_any, dec_out_err_vec, dec_out_data},
        64'd0);
    chk("R1 reset clears enc", 64'(enc_out_word), 64'd0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule